// File: doc/BRIEF.md
# LIN Master Header Transmitter

This block produces the header of a LIN frame when the chip acts as bus master. A start command drives the transmit line low for a programmable break period. A prescaler and a down-counter time that period, which does not depend on the serial baud rate. When the counter underflows, the line is released and a sticky break-done flag is set. An optional one-cycle interrupt pulse is raised at the same time.

After the break, the line stays high for a one-bit delimiter. The block then sends the synchronization byte 0x55 through its own byte-serial transmitter. The identifier byte follows back to back. The identifier is latched when the header starts. When the identifier stop bit has been sent, the busy output drops and a one-cycle pulse tells the response logic that it may begin. An abort input returns the block to idle at any time, with the line high.

Top module: `lin_hdr_tx`

## Requirements
- R1: A start request has no effect unless both `lin_en_i` and `master_i` are 1: `busy_o` stays 0 and `txd_o` stays 1.
- R2: An accepted `start_i` (while idle) makes `txd_o` 0 and `busy_o` 1 in the next cycle.
- R3: The break lasts exactly (`brk_pre_i`+1)×(`brk_cnt_i`+1) clock cycles, with both values taken at start.
- R4: When the break ends, `txd_o` returns to 1 for a delimiter of D = `baud_div_i`+1 cycles, and `brk_done_o` becomes 1 in the first delimiter cycle.
- R5: If `brk_irq_en_i` is 1, `irq_o` is 1 for exactly the first delimiter cycle. If it is 0, `irq_o` stays 0.
- R6: `brk_done_o` stays 1 until a cycle with `brk_clr_i` or `irq_ack_i` at 1. It is 0 from the following cycle. A new break end has priority over a clear in the same cycle.
- R7: Each byte frame is a start bit of 0, then 8 data bits with the LSB first, then a stop bit of 1. Each bit lasts D cycles. The first frame carries 0x55 and begins right after the delimiter.
- R8: The identifier frame begins immediately after the sync stop bit. It carries the value `id_i` had in the cycle start was accepted.
- R9: `busy_o` stays 1 until the identifier stop bit has ended. In the cycle `busy_o` first reads 0, `resp_go_o` is 1 for that one cycle.
- R10: `start_i` asserted while `busy_o` is 1 is ignored: the running header continues unchanged.
- R11: `abort_i` makes `busy_o` 0 and `txd_o` 1 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lin_en_i | input | 1 | LIN function enable |
| master_i | input | 1 | Master mode select |
| start_i | input | 1 | Write-one start of a header |
| abort_i | input | 1 | Return to idle |
| brk_irq_en_i | input | 1 | Break-end interrupt enable |
| brk_clr_i | input | 1 | Write-one clear of break-done flag |
| irq_ack_i | input | 1 | Interrupt acknowledge, clears flag |
| brk_pre_i | input | 8 | Break prescaler reload value |
| brk_cnt_i | input | 8 | Break counter reload value |
| baud_div_i | input | 8 | Bit period minus one, in clocks |
| id_i | input | 8 | Identifier byte |
| txd_o | output | 1 | Transmit line, idle high |
| busy_o | output | 1 | Header in progress |
| brk_done_o | output | 1 | Sticky break-done flag |
| irq_o | output | 1 | Break-end interrupt pulse |
| resp_go_o | output | 1 | Response phase may begin (pulse) |

## Verification
The hardest point to reach is the boundary where one frame hands over to the next. The sync stop bit must end on the same clock edge that loads the identifier frame. A start request landing inside that window must not restart anything. The stimulus decodes every bit at its mid-point across several baud divisors, including a one-clock bit. It asserts start at the sync stop-bit mid-point, then checks that the identifier frame still follows with no gap and carries the identifier latched at start. The bench changes `id_i` during the header, so a design that read the identifier late would send the wrong value.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BRK,
    ST_DLM,
    ST_SYNC,
    ST_ID
  } hdr_state_e;

  localparam logic [7:0] SYNC_BYTE = 8'h55;
  localparam int unsigned FRAME_BITS = 10;
endpackage

// File: rtl/lin_brk_timer.sv
module lin_brk_timer #(
  parameter int unsigned PRE_W = 8,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [PRE_W-1:0] pre_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             uflow_o
);
  logic [PRE_W-1:0] pre_q, pc_q;
  logic [CNT_W-1:0] cc_q;

  assign uflow_o = run_i && (pc_q == '0) && (cc_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      pc_q  <= '0;
      cc_q  <= '0;
    end else if (load_i) begin
      pre_q <= pre_i;
      pc_q  <= pre_i;
      cc_q  <= cnt_i;
    end else if (run_i) begin
      if (pc_q == '0) begin
        pc_q <= pre_q;
        if (cc_q != '0) cc_q <= cc_q - 1'b1;
      end else begin
        pc_q <= pc_q - 1'b1;
      end
    end
  end

  // run drops on the edge that consumes the underflow
  p_uflow_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uflow_o |=> !uflow_o);
endmodule

// File: rtl/lin_uart_tx.sv
module lin_uart_tx #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             ld_i,
  input  logic [7:0]       data_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tx_o,
  output logic             done_o
);
  import lin_hdr_pkg::*;
  localparam int unsigned BC_W = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] sh_q;
  logic [BC_W-1:0]       bc_q;
  logic [DIV_W-1:0]      dv_q, div_q;
  logic                  act_q;

  assign done_o = act_q && (dv_q == '0) && (bc_q == '0);
  assign tx_o   = act_q ? sh_q[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '1;
      bc_q  <= '0;
      dv_q  <= '0;
      div_q <= '0;
      act_q <= 1'b0;
    end else if (clr_i) begin
      act_q <= 1'b0;
      sh_q  <= '1;
    end else if (ld_i) begin
      sh_q  <= {1'b1, data_i, 1'b0};
      bc_q  <= BC_W'(FRAME_BITS - 1);
      dv_q  <= div_i;
      div_q <= div_i;
      act_q <= 1'b1;
    end else if (act_q) begin
      if (dv_q == '0) begin
        if (bc_q == '0) begin
          act_q <= 1'b0;
        end else begin
          sh_q <= {1'b1, sh_q[FRAME_BITS-1:1]};
          bc_q <= bc_q - 1'b1;
          dv_q <= div_q;
        end
      end else begin
        dv_q <= dv_q - 1'b1;
      end
    end
  end

  // a new byte is loaded only into an idle shifter or on the last stop cycle
  p_ld_no_overlap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |-> (!act_q || done_o));
endmodule

// File: rtl/lin_hdr_seq.sv
module lin_hdr_seq #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             lin_en_i,
  input  logic             master_i,
  input  logic             abort_i,
  input  logic             irq_en_i,
  input  logic             clr_i,
  input  logic             ack_i,
  input  logic [7:0]       id_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             uflow_i,
  input  logic             uart_done_i,
  output logic             tmr_load_o,
  output logic             tmr_run_o,
  output logic             ld_o,
  output logic [7:0]       ld_data_o,
  output logic [DIV_W-1:0] div_o,
  output logic             uart_clr_o,
  output logic             brk_low_o,
  output logic             busy_o,
  output logic             brk_done_o,
  output logic             irq_o,
  output logic             resp_go_o
);
  import lin_hdr_pkg::*;

  hdr_state_e       st_q;
  logic [DIV_W-1:0] dc_q, div_q;
  logic [7:0]       id_q;
  logic             flag_q, irq_q, resp_q, accept;

  assign accept     = (st_q == ST_IDLE) && start_i && lin_en_i && master_i && !abort_i;
  assign tmr_load_o = accept;
  assign tmr_run_o  = (st_q == ST_BRK);
  assign ld_o       = !abort_i && (((st_q == ST_DLM) && (dc_q == '0)) ||
                                   ((st_q == ST_SYNC) && uart_done_i));
  assign ld_data_o  = (st_q == ST_DLM) ? SYNC_BYTE : id_q;
  assign div_o      = div_q;
  assign uart_clr_o = abort_i;
  assign brk_low_o  = (st_q == ST_BRK);
  assign busy_o     = (st_q != ST_IDLE);
  assign brk_done_o = flag_q;
  assign irq_o      = irq_q;
  assign resp_go_o  = resp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      dc_q   <= '0;
      div_q  <= '0;
      id_q   <= '0;
      resp_q <= 1'b0;
    end else begin
      resp_q <= 1'b0;
      if (abort_i) begin
        st_q <= ST_IDLE;
      end else begin
        unique case (st_q)
          ST_IDLE: if (accept) begin
            st_q  <= ST_BRK;
            id_q  <= id_i;
            div_q <= div_i;
          end
          ST_BRK: if (uflow_i) begin
            st_q <= ST_DLM;
            dc_q <= div_q;
          end
          ST_DLM: begin
            if (dc_q == '0) st_q <= ST_SYNC;
            else            dc_q <= dc_q - 1'b1;
          end
          ST_SYNC: if (uart_done_i) st_q <= ST_ID;
          ST_ID: if (uart_done_i) begin
            st_q   <= ST_IDLE;
            resp_q <= 1'b1;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= uflow_i && irq_en_i;
      if (uflow_i)            flag_q <= 1'b1;
      else if (clr_i || ack_i) flag_q <= 1'b0;
    end
  end

  p_flag_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i || ack_i) && !uflow_i) |=> !flag_q);
  p_id_held_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(id_q));
endmodule

// File: rtl/lin_hdr_tx.sv
module lin_hdr_tx #(
  parameter int unsigned PRE_W = 8,
  parameter int unsigned CNT_W = 8,
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lin_en_i,
  input  logic             master_i,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic             brk_irq_en_i,
  input  logic             brk_clr_i,
  input  logic             irq_ack_i,
  input  logic [PRE_W-1:0] brk_pre_i,
  input  logic [CNT_W-1:0] brk_cnt_i,
  input  logic [DIV_W-1:0] baud_div_i,
  input  logic [7:0]       id_i,
  output logic             txd_o,
  output logic             busy_o,
  output logic             brk_done_o,
  output logic             irq_o,
  output logic             resp_go_o
);
  logic             tmr_load, tmr_run, uflow;
  logic             ld, uart_clr, uart_tx, uart_done, brk_low;
  logic [7:0]       ld_data;
  logic [DIV_W-1:0] div_lat;

  lin_brk_timer #(.PRE_W(PRE_W), .CNT_W(CNT_W)) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (tmr_load),
    .run_i   (tmr_run),
    .pre_i   (brk_pre_i),
    .cnt_i   (brk_cnt_i),
    .uflow_o (uflow)
  );

  lin_hdr_seq #(.DIV_W(DIV_W)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .lin_en_i    (lin_en_i),
    .master_i    (master_i),
    .abort_i     (abort_i),
    .irq_en_i    (brk_irq_en_i),
    .clr_i       (brk_clr_i),
    .ack_i       (irq_ack_i),
    .id_i        (id_i),
    .div_i       (baud_div_i),
    .uflow_i     (uflow),
    .uart_done_i (uart_done),
    .tmr_load_o  (tmr_load),
    .tmr_run_o   (tmr_run),
    .ld_o        (ld),
    .ld_data_o   (ld_data),
    .div_o       (div_lat),
    .uart_clr_o  (uart_clr),
    .brk_low_o   (brk_low),
    .busy_o      (busy_o),
    .brk_done_o  (brk_done_o),
    .irq_o       (irq_o),
    .resp_go_o   (resp_go_o)
  );

  lin_uart_tx #(.DIV_W(DIV_W)) i_uart (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (uart_clr),
    .ld_i   (ld),
    .data_i (ld_data),
    .div_i  (div_lat),
    .tx_o   (uart_tx),
    .done_o (uart_done)
  );

  assign txd_o = !brk_low && uart_tx;

  p_gate_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !(lin_en_i && master_i)) |=> !busy_o);
  p_start_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && lin_en_i && master_i && !abort_i) |=> (!txd_o && busy_o));
  p_flag_line_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(brk_done_o) |-> txd_o);
  p_irq_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> brk_done_o);
  p_resp_end_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_go_o |-> (!busy_o && $past(busy_o)));
  p_abort_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (!busy_o && txd_o));
endmodule

// File: tb/test_lin_hdr_tx.sv
`timescale 1ns/1ps
module test_lin_hdr_tx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic lin_en = 0, master = 0, start = 0, abort_s = 0, ien = 0, clr = 0, ack = 0;
  logic [7:0] pre = 0, cnt = 0, div = 0, id = 0;
  logic txd, busy, bdone, irq, resp;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  lin_hdr_tx i_lin_hdr_tx (
    .clk_i(clk), .rst_ni(rst_n), .lin_en_i(lin_en), .master_i(master),
    .start_i(start), .abort_i(abort_s), .brk_irq_en_i(ien), .brk_clr_i(clr),
    .irq_ack_i(ack), .brk_pre_i(pre), .brk_cnt_i(cnt), .baud_div_i(div),
    .id_i(id), .txd_o(txd), .busy_o(busy), .brk_done_o(bdone), .irq_o(irq),
    .resp_go_o(resp)
  );

  // {pre, cnt, div, id, irq_en, start_while_busy, clear_by_ack}
  localparam int NV = 5;
  localparam logic [34:0] VEC [NV] = '{
    {8'd2, 8'd3, 8'd3, 8'hA7, 1'b1, 1'b0, 1'b0},
    {8'd0, 8'd0, 8'd0, 8'h3C, 1'b0, 1'b1, 1'b1},
    {8'd4, 8'd1, 8'd4, 8'h01, 1'b1, 1'b1, 1'b0},
    {8'd1, 8'd5, 8'd7, 8'hFE, 1'b0, 1'b0, 1'b1},
    {8'd0, 8'd9, 8'd1, 8'h80, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // entered at the first cycle of a start bit; leaves at the stop-bit mid-point
  task automatic rx_byte(input int d, output logic [9:0] bits);
    for (int b = 0; b < 10; b++) begin
      tick(b == 0 ? d / 2 : d);
      bits[b] = txd;
    end
  endtask

  task automatic run_hdr(input logic [34:0] v);
    int d, n, m;
    logic [9:0] f;
    logic [7:0] idv;
    pre = v[34:27]; cnt = v[26:19]; div = v[18:11]; idv = v[10:3]; ien = v[2];
    id = idv; d = int'(div) + 1;
    start = 1; tick(1); start = 0; id = ~idv;
    chk(!txd && busy, "R2 start", {30'd0, busy, txd}, 2);
    n = 0;
    while (!txd && n < 100000) begin n++; tick(1); end
    chk(n == (int'(pre) + 1) * (int'(cnt) + 1), "R3 break length", n,
        (int'(pre) + 1) * (int'(cnt) + 1));
    chk(bdone, "R4 flag set", bdone, 1);
    chk(irq == ien, "R5 irq pulse", irq, ien);
    tick(1);
    chk(!irq, "R5 irq one cycle", irq, 0);
    m = 1;
    while (txd && m < 100000) begin m++; tick(1); end
    chk(m == d, "R4 delimiter", m, d);
    rx_byte(d, f);
    chk(f[0] == 0 && f[9] == 1 && f[8:1] == 8'h55, "R7 sync frame", f, {1'b1, 8'h55, 1'b0});
    if (v[1]) start = 1;
    tick(d - d / 2);
    start = 0;
    rx_byte(d, f);
    chk(f[0] == 0 && f[9] == 1 && f[8:1] == idv, "R8 R10 id frame", f, {1'b1, idv, 1'b0});
    chk(busy, "R9 busy at id stop", busy, 1);
    tick(d - d / 2);
    chk(!busy && resp, "R9 end", {busy, resp}, 1);
    tick(1);
    chk(!resp && !busy && txd, "R9 R10 resp single, no restart", {resp, busy, txd}, 1);
    chk(bdone, "R6 flag sticky", bdone, 1);
    if (v[0]) ack = 1; else clr = 1;
    tick(1); ack = 0; clr = 0;
    chk(!bdone, "R6 flag clear", bdone, 0);
    tick(2);
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(3);
    chk(txd && !busy && !bdone && !irq && !resp, "R2 reset state",
        {busy, bdone, irq, resp}, 0);
    rst_n = 1; tick(2);
    // R1 gating
    lin_en = 0; master = 1; pre = 3; cnt = 3; start = 1; tick(1); start = 0; tick(1);
    chk(!busy && txd, "R1 disabled", busy, 0);
    lin_en = 1; master = 0; start = 1; tick(1); start = 0; tick(1);
    chk(!busy && txd, "R1 slave", busy, 0);
    master = 1;
    for (int i = 0; i < NV; i++) run_hdr(VEC[i]);
    // R11 abort in break
    pre = 5; cnt = 5; div = 2; start = 1; tick(1); start = 0; tick(3);
    chk(!txd, "R11 in break", txd, 0);
    abort_s = 1; tick(1); abort_s = 0;
    chk(!busy && txd, "R11 abort break", busy, 0);
    tick(40);
    chk(!busy && txd, "R11 stays idle", busy, 0);
    // R11 abort during a frame
    pre = 0; cnt = 0; start = 1; tick(1); start = 0; tick(6);
    chk(busy, "R11 busy before abort", busy, 1);
    abort_s = 1; tick(1); abort_s = 0;
    chk(!busy && txd, "R11 abort frame", busy, 0);
    tick(40);
    chk(txd && !resp, "R11 no resume", resp, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule